// File: doc/BRIEF.md
# Active Video Boundary Meter

This block watches a stream of sampled RGB pixels, one per clock, together with horizontal and vertical sync levels. It reports where the picture content sits inside the raster. Four numbers describe this: the blank pixels between the end of the line sync and the first lit pixel, the blank lines between the end of the frame sync and the first lit line, the width of the lit area in pixels and its height in lines. Auto-adjust firmware reads these numbers to tune a sampling clock until the measured width matches the expected mode width, and to position the capture window.

A pixel counts as lit when at least one of its three colour channels reaches a programmable threshold. The block also latches the colour of one chosen pixel, given by a programmable line and pixel coordinate, so that sampling phase and channel gains can be tuned against a known point of the image. Every result is double-buffered and commits at the start of the frame sync, so a read never mixes two frames.

Top module: `active_video_meter`

## Requirements
- R1: `porch_pix` reports the smallest pixel index, over all lines of the frame, that holds a lit pixel. Index 0 is the first clock with both syncs low after the line sync (active high) falls, and the index advances once per clock while both syncs stay low.
- R2: `porch_lines` reports the index of the first line that holds a lit pixel. Line index 0 is the first line after the frame sync (active high) falls, and the index advances at each rising edge of the line sync that closes a line with at least one pixel.
- R3: `act_pix` reports the largest value, over all lines, of (last lit pixel index − first lit pixel index + 1) within one line.
- R4: `act_lines` reports (last lit line index − first lit line index + 1).
- R5: A pixel is blank only when red, green and blue are all strictly below `thresh`. A channel equal to `thresh` makes the pixel lit.
- R6: `ref_r`, `ref_g` and `ref_b` report the colour of the pixel at line `ref_line`, pixel index `ref_pix` of the last finished frame.
- R7: If the frame holds no pixel at the reference coordinate, `ref_r`, `ref_g` and `ref_b` read zero after that frame commits.
- R8: All seven results change only on the clock edge at which `vsync` is first seen high after being low, and they change together. The frame that is ending is measured up to and including its last pixel.
- R9: A frame with no lit pixel reports `act_pix` = 0 and `act_lines` = 0. `porch_pix` then equals the pixel count of the longest line and `porch_lines` equals the number of lines in the frame.
- R10: After synchronous reset all results read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | pixel sample clock |
| rst | input | 1 | synchronous reset, active high |
| hsync | input | 1 | line sync level, active high |
| vsync | input | 1 | frame sync level, active high |
| pix_r | input | 8 | red sample |
| pix_g | input | 8 | green sample |
| pix_b | input | 8 | blue sample |
| thresh | input | 8 | lit/blank threshold |
| ref_line | input | 11 | reference pixel line index |
| ref_pix | input | 12 | reference pixel index within the line |
| porch_pix | output | 12 | horizontal blank count before content |
| act_pix | output | 12 | widest lit span in pixels |
| porch_lines | output | 11 | vertical blank count before content |
| act_lines | output | 11 | lit line span |
| ref_r | output | 8 | captured reference red |
| ref_g | output | 8 | captured reference green |
| ref_b | output | 8 | captured reference blue |

## Verification
The bench aims at a single lit pixel in the last slot of the last line. A design that folded only on line-sync edges would lose it and report an empty frame. A ragged frame, where odd lines start earlier, catches a design that keeps the first line's edges instead of the minimum start and the maximum span. A channel exactly at the threshold, and a frame whose channels all sit one below it, catch an off-by-one in the compare and a wrong fallback for empty frames. Mid-frame reads and an unreachable reference coordinate expose results or captures that leak before the frame commits, or stale values that survive it.

// File: rtl/avm_pkg.sv
package avm_pkg;
    parameter int unsigned COL_W  = 8;
    parameter int unsigned PIX_W  = 12;
    parameter int unsigned LINE_W = 11;
    parameter int unsigned NUM_CH = 3;

    typedef logic [COL_W-1:0]  chan_t;
    typedef logic [PIX_W-1:0]  xpos_t;
    typedef logic [LINE_W-1:0] ypos_t;

    typedef struct packed {
        chan_t r;
        chan_t g;
        chan_t b;
    } rgb_t;

    typedef struct packed {
        xpos_t porch_pix;
        xpos_t act_pix;
        ypos_t porch_lines;
        ypos_t act_lines;
    } meas_t;

    function automatic xpos_t xsat_inc(input xpos_t v);
        return (&v) ? v : v + 1'b1;
    endfunction

    function automatic ypos_t ysat_inc(input ypos_t v);
        return (&v) ? v : v + 1'b1;
    endfunction

    function automatic xpos_t xmin(input xpos_t a, input xpos_t b);
        return (a < b) ? a : b;
    endfunction

    function automatic xpos_t xmax(input xpos_t a, input xpos_t b);
        return (a > b) ? a : b;
    endfunction
endpackage

// File: rtl/avm_raster.sv
module avm_raster
    import avm_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  hsync,
    input  logic  vsync,
    output xpos_t x,
    output ypos_t y,
    output logic  pix_en,
    output logic  line_end,
    output logic  commit
);
    logic vs_q;

    assign pix_en   = !hsync && !vsync;
    assign line_end = hsync && !vsync && (x != '0);
    assign commit   = vsync && !vs_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            vs_q <= 1'b1;
            x    <= '0;
            y    <= '0;
        end else begin
            vs_q <= vsync;
            if (!pix_en) begin
                x <= '0;
            end else begin
                x <= xsat_inc(x);
            end
            if (vsync) begin
                y <= '0;
            end else if (line_end) begin
                y <= ysat_inc(y);
            end
        end
    end

    assert_x_cleared_R1: assert property (@(posedge clk) disable iff (rst)
        hsync |=> (x == '0));

    assert_y_cleared_R2: assert property (@(posedge clk) disable iff (rst)
        vsync |=> (y == '0));
endmodule

// File: rtl/avm_classify.sv
module avm_classify
    import avm_pkg::*;
(
    input  rgb_t  pix,
    input  chan_t thresh,
    input  logic  pix_en,
    output logic  active
);
    chan_t             ch [NUM_CH];
    logic [NUM_CH-1:0] over;

    assign ch[0] = pix.r;
    assign ch[1] = pix.g;
    assign ch[2] = pix.b;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        assign over[c] = (ch[c] >= thresh);
    end

    assign active = pix_en && (|over);
endmodule

// File: rtl/avm_span_acc.sv
module avm_span_acc
    import avm_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  pix_en,
    input  logic  active,
    input  xpos_t x,
    input  ypos_t y,
    input  logic  line_end,
    input  logic  commit,
    output meas_t res
);
    // current-line edges
    logic  ln_any;
    xpos_t ln_first;
    xpos_t ln_last;
    // frame-so-far summary
    logic  fr_any;
    xpos_t fr_first;
    xpos_t fr_span;
    ypos_t fr_fline;
    ypos_t fr_lline;
    xpos_t fr_len;
    // frame merged with the line in progress
    xpos_t ln_span;
    logic  m_any;
    xpos_t m_first;
    xpos_t m_span;
    ypos_t m_fline;
    ypos_t m_lline;
    xpos_t m_len;
    ypos_t tot_lines;
    meas_t res_next;

    assign ln_span = ln_last - ln_first + 1'b1;

    always_comb begin
        m_any   = fr_any || ln_any;
        m_first = fr_any ? (ln_any ? xmin(fr_first, ln_first) : fr_first) : ln_first;
        m_span  = (ln_any && (!fr_any || ln_span > fr_span)) ? ln_span : fr_span;
        m_fline = fr_any ? fr_fline : y;
        m_lline = ln_any ? y : fr_lline;
        m_len   = xmax(fr_len, x);
        tot_lines = (x != '0) ? ysat_inc(y) : y;

        if (m_any) begin
            res_next.porch_pix   = m_first;
            res_next.act_pix     = m_span;
            res_next.porch_lines = m_fline;
            res_next.act_lines   = m_lline - m_fline + 1'b1;
        end else begin
            res_next.porch_pix   = m_len;
            res_next.act_pix     = '0;
            res_next.porch_lines = tot_lines;
            res_next.act_lines   = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ln_any   <= 1'b0;
            ln_first <= '0;
            ln_last  <= '0;
        end else if (!pix_en) begin
            ln_any   <= 1'b0;
            ln_first <= '0;
            ln_last  <= '0;
        end else if (active) begin
            ln_any  <= 1'b1;
            ln_last <= x;
            if (!ln_any) begin
                ln_first <= x;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || commit) begin
            fr_any   <= 1'b0;
            fr_first <= '0;
            fr_span  <= '0;
            fr_fline <= '0;
            fr_lline <= '0;
            fr_len   <= '0;
        end else if (line_end) begin
            fr_any   <= m_any;
            fr_first <= m_first;
            fr_span  <= m_span;
            fr_fline <= m_fline;
            fr_lline <= m_lline;
            fr_len   <= m_len;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res <= '0;
        end else if (commit) begin
            res <= res_next;
        end
    end

    assert_hold_between_frames_R8: assert property (@(posedge clk) disable iff (rst)
        !commit |=> $stable(res));

    assert_act_lines_nonzero_R4: assert property (@(posedge clk) disable iff (rst)
        (commit && m_any) |=> (res.act_lines != '0));

    assert_empty_pair_R9: assert property (@(posedge clk) disable iff (rst)
        (res.act_pix == '0) == (res.act_lines == '0));
endmodule

// File: rtl/avm_ref_grab.sv
module avm_ref_grab
    import avm_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  pix_en,
    input  logic  commit,
    input  xpos_t x,
    input  ypos_t y,
    input  xpos_t ref_x,
    input  ypos_t ref_y,
    input  rgb_t  pix,
    output rgb_t  ref_out
);
    rgb_t shadow;
    logic hit;

    assign hit = pix_en && (x == ref_x) && (y == ref_y);

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow  <= '0;
            ref_out <= '0;
        end else if (commit) begin
            shadow  <= '0;
            ref_out <= shadow;
        end else if (hit) begin
            shadow <= pix;
        end
    end

    assert_ref_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !commit |=> $stable(ref_out));

    assert_no_grab_in_sync_R6: assert property (@(posedge clk) disable iff (rst)
        (commit && !$past(hit)) |=> (ref_out == $past(shadow)));
endmodule

// File: rtl/active_video_meter.sv
module active_video_meter
    import avm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              hsync,
    input  logic              vsync,
    input  logic [COL_W-1:0]  pix_r,
    input  logic [COL_W-1:0]  pix_g,
    input  logic [COL_W-1:0]  pix_b,
    input  logic [COL_W-1:0]  thresh,
    input  logic [LINE_W-1:0] ref_line,
    input  logic [PIX_W-1:0]  ref_pix,
    output logic [PIX_W-1:0]  porch_pix,
    output logic [PIX_W-1:0]  act_pix,
    output logic [LINE_W-1:0] porch_lines,
    output logic [LINE_W-1:0] act_lines,
    output logic [COL_W-1:0]  ref_r,
    output logic [COL_W-1:0]  ref_g,
    output logic [COL_W-1:0]  ref_b
);
    rgb_t  pix;
    xpos_t x;
    ypos_t y;
    logic  pix_en;
    logic  line_end;
    logic  commit;
    logic  active;
    meas_t res;
    rgb_t  ref_val;

    assign pix = '{r: pix_r, g: pix_g, b: pix_b};

    avm_raster u_raster (
        .clk      (clk),
        .rst      (rst),
        .hsync    (hsync),
        .vsync    (vsync),
        .x        (x),
        .y        (y),
        .pix_en   (pix_en),
        .line_end (line_end),
        .commit   (commit)
    );

    avm_classify u_classify (
        .pix    (pix),
        .thresh (thresh),
        .pix_en (pix_en),
        .active (active)
    );

    avm_span_acc u_span (
        .clk      (clk),
        .rst      (rst),
        .pix_en   (pix_en),
        .active   (active),
        .x        (x),
        .y        (y),
        .line_end (line_end),
        .commit   (commit),
        .res      (res)
    );

    avm_ref_grab u_ref (
        .clk     (clk),
        .rst     (rst),
        .pix_en  (pix_en),
        .commit  (commit),
        .x       (x),
        .y       (y),
        .ref_x   (ref_pix),
        .ref_y   (ref_line),
        .pix     (pix),
        .ref_out (ref_val)
    );

    assign porch_pix   = res.porch_pix;
    assign act_pix     = res.act_pix;
    assign porch_lines = res.porch_lines;
    assign act_lines   = res.act_lines;
    assign ref_r       = ref_val.r;
    assign ref_g       = ref_val.g;
    assign ref_b       = ref_val.b;
endmodule

// File: tb/sim_active_video_meter.sv
module sim_active_video_meter;
    logic        clk = 1'b0;
    logic        rst;
    logic        hsync, vsync;
    logic [7:0]  pix_r, pix_g, pix_b, thresh;
    logic [10:0] ref_line;
    logic [11:0] ref_pix;
    logic [11:0] porch_pix, act_pix;
    logic [10:0] porch_lines, act_lines;
    logic [7:0]  ref_r, ref_g, ref_b;

    int tests = 0;
    int fails = 0;
    bit cmp_on = 1'b0;

    always #5 clk = ~clk;

    active_video_meter u0 (
        .clk(clk), .rst(rst), .hsync(hsync), .vsync(vsync),
        .pix_r(pix_r), .pix_g(pix_g), .pix_b(pix_b), .thresh(thresh),
        .ref_line(ref_line), .ref_pix(ref_pix),
        .porch_pix(porch_pix), .act_pix(act_pix),
        .porch_lines(porch_lines), .act_lines(act_lines),
        .ref_r(ref_r), .ref_g(ref_g), .ref_b(ref_b)
    );

    task automatic chk(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int          m_x, cf, cl;
    bit          m_vq;
    int          q_f[$], q_l[$], q_n[$];
    logic [23:0] pend;
    int          ex_pp, ex_ap, ex_pl, ex_al;
    logic [23:0] ex_ref;

    always @(posedge clk) begin : model
        int any, fl, ll, mf, ms, mn;
        bit lit;
        if (rst) begin
            m_x = 0; cf = -1; cl = -1; m_vq = 1'b1; pend = '0;
            q_f.delete(); q_l.delete(); q_n.delete();
            ex_pp = 0; ex_ap = 0; ex_pl = 0; ex_al = 0; ex_ref = '0;
        end else begin
            if (vsync && !m_vq) begin
                if (m_x > 0) begin
                    q_f.push_back(cf); q_l.push_back(cl); q_n.push_back(m_x);
                end
                any = 0; fl = 0; ll = 0; mf = 0; ms = 0; mn = 0;
                foreach (q_f[i]) begin
                    if (q_n[i] > mn) mn = q_n[i];
                    if (q_f[i] >= 0) begin
                        if (any == 0 || q_f[i] < mf) mf = q_f[i];
                        if (q_l[i] - q_f[i] + 1 > ms) ms = q_l[i] - q_f[i] + 1;
                        if (any == 0) fl = i;
                        ll = i;
                        any = 1;
                    end
                end
                ex_pp  = any ? mf : mn;
                ex_ap  = any ? ms : 0;
                ex_pl  = any ? fl : q_f.size();
                ex_al  = any ? ll - fl + 1 : 0;
                ex_ref = pend;
                pend   = '0;
                q_f.delete(); q_l.delete(); q_n.delete();
                m_x = 0; cf = -1; cl = -1;
            end else if (!vsync) begin
                if (hsync) begin
                    if (m_x > 0) begin
                        q_f.push_back(cf); q_l.push_back(cl); q_n.push_back(m_x);
                    end
                    m_x = 0; cf = -1; cl = -1;
                end else begin
                    lit = (pix_r >= thresh) || (pix_g >= thresh) || (pix_b >= thresh);
                    if (lit) begin
                        if (cf < 0) cf = m_x;
                        cl = m_x;
                    end
                    if (q_f.size() == int'(ref_line) && m_x == int'(ref_pix))
                        pend = {pix_r, pix_g, pix_b};
                    m_x++;
                end
            end else begin
                m_x = 0; cf = -1; cl = -1;
            end
            m_vq = vsync;
        end
    end

    always @(negedge clk) begin
        if (cmp_on) begin
            chk("R1 model porch_pix", porch_pix, ex_pp);
            chk("R3 model act_pix", act_pix, ex_ap);
            chk("R2 model porch_lines", porch_lines, ex_pl);
            chk("R4 model act_lines", act_lines, ex_al);
            chk("R6 model ref", {ref_r, ref_g, ref_b}, ex_ref);
        end
    end

    // ---------------- stimulus ----------------
    int          pv_pp = 0, pv_ap = 0, pv_pl = 0, pv_al = 0;
    logic [23:0] pv_ref = '0;

    task automatic run_frame(input string nm, input int nl, input int len,
                             input int xs, input int xe, input int ys, input int ye,
                             input int ext, input logic [23:0] fg, input logic [23:0] bg,
                             input int th, input int rl, input int rp,
                             input int e_pp, input int e_ap, input int e_pl, input int e_al,
                             input logic [23:0] e_ref);
        thresh = th[7:0]; ref_line = rl[10:0]; ref_pix = rp[11:0];
        for (int l = 0; l < nl; l++) begin
            for (int k = 0; k < 2; k++) begin
                vsync = 1'b0; hsync = 1'b1; {pix_r, pix_g, pix_b} = bg;
                @(negedge clk);
            end
            for (int x = 0; x < len; x++) begin
                int lo;
                lo = (l % 2 == 1) ? xs - ext : xs;
                hsync = 1'b0;
                {pix_r, pix_g, pix_b} = (l >= ys && l <= ye && x >= lo && x <= xe) ? fg : bg;
                @(negedge clk);
            end
            if (l == 1) begin
                // R8: nothing of the running frame may show yet
                chk({"R8 mid-frame porch_pix ", nm}, porch_pix, pv_pp);
                chk({"R8 mid-frame act_pix ", nm}, act_pix, pv_ap);
                chk({"R8 mid-frame ref ", nm}, {ref_r, ref_g, ref_b}, pv_ref);
            end
        end
        vsync = 1'b1; hsync = 1'b0; {pix_r, pix_g, pix_b} = bg;
        @(negedge clk);
        chk({"R1 porch_pix ", nm}, porch_pix, e_pp);
        chk({"R3 act_pix ", nm}, act_pix, e_ap);
        chk({"R2 porch_lines ", nm}, porch_lines, e_pl);
        chk({"R4 act_lines ", nm}, act_lines, e_al);
        chk({"R6 ref colour ", nm}, {ref_r, ref_g, ref_b}, e_ref);
        pv_pp = e_pp; pv_ap = e_ap; pv_pl = e_pl; pv_al = e_al; pv_ref = e_ref;
        @(negedge clk);
    endtask

    initial begin
        rst = 1'b1; vsync = 1'b1; hsync = 1'b0;
        pix_r = '0; pix_g = '0; pix_b = '0; thresh = 8'h40;
        ref_line = '0; ref_pix = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R10 reset porch_pix", porch_pix, 0);
        chk("R10 reset act_pix", act_pix, 0);
        chk("R10 reset porch_lines", porch_lines, 0);
        chk("R10 reset act_lines", act_lines, 0);
        chk("R10 reset ref", {ref_r, ref_g, ref_b}, 0);
        cmp_on = 1'b1;

        // box with red over threshold; reference inside the box (R5, R6)
        run_frame("box", 8, 20, 5, 14, 2, 5, 0, 24'h801010, 24'h101010,
                  'h40, 3, 7, 5, 10, 2, 4, 24'h801010);
        // green exactly at threshold (R5), full-width line 0, ref on last pixel
        run_frame("edge", 6, 16, 0, 15, 0, 0, 0, 24'h004000, 24'h3F3F3F,
                  'h40, 5, 15, 0, 16, 0, 1, 24'h3F3F3F);
        // ragged: odd lines start 3 earlier (R1, R3); ref unreachable (R7)
        run_frame("ragged", 10, 24, 8, 17, 3, 8, 3, 24'h1010C0, 24'h000000,
                  'h40, 20, 0, 5, 13, 3, 6, 24'h000000);
        // all channels one below threshold: empty frame (R9, R5)
        run_frame("empty", 7, 18, 0, 17, 0, 6, 0, 24'h3F3F3F, 24'h3F3F3F,
                  'h40, 0, 0, 18, 0, 7, 0, 24'h3F3F3F);
        // raised threshold turns the box blank (R5, R9)
        run_frame("raised", 8, 20, 5, 14, 2, 5, 0, 24'h801010, 24'h101010,
                  'h90, 3, 7, 20, 0, 8, 0, 24'h801010);
        // single lit pixel in the last slot of the last line (R8 tail merge)
        run_frame("tail", 5, 12, 11, 11, 4, 4, 0, 24'hFFFFFF, 24'h000000,
                  'h40, 4, 11, 11, 1, 4, 1, 24'hFFFFFF);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog R8 actual=running expected=finished");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule